// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Flag Unit

This block is the ALU slice of an 8-bit accumulator CPU that rotates one operand byte left by a single bit position through the carry flag. The bit that leaves the top of the byte becomes the new carry. The old carry enters at the bottom. Alongside the rotated byte it produces the four condition flags (zero, subtract, half-carry, carry) and the number of clock ticks that the instruction costs.

A mode input chooses between two instruction forms. The short form works on the accumulator. The prefixed form works on a general register. The two forms differ only in how the zero flag is set and in their cycle cost.

The rotate, flag and cost logic is purely combinational. The top level is a thin registered wrapper. It captures the result, the flags and the cost on each clock edge where the valid strobe is high, and it holds them otherwise.

Top module: `rlc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every registered output (`result`, all four flags, `cycles`, `valid_out`) is cleared to zero.
- R2: One clock edge after `valid_in` is high, `result` equals the operand shifted left by one, with bit 0 taken from `carry_in`.
- R3: One clock edge after `valid_in` is high, `flag_c` equals bit 7 of the operand as it was before the rotate.
- R4: The captured subtract flag `flag_n` and half-carry flag `flag_h` are 0 in both modes.
- R5: With `mode` = 0 (accumulator form), the captured `flag_z` is 0 for every operand, including one whose rotated result is 0x00.
- R6: With `mode` = 1 (prefixed register form), the captured `flag_z` is 1 exactly when the 8-bit result is 0x00.
- R7: The captured `cycles` is 4 for `mode` = 0 and 8 for `mode` = 1.
- R8: At an edge where `valid_in` is low, `result`, the flags and `cycles` keep their previous values whatever the data inputs are.
- R9: `valid_out` is high for exactly the cycle that follows an edge at which `valid_in` was high.
- R10: Operand 0x80 with `carry_in` 0 gives result 0x00 and carry 1. Zero is then set only in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Capture strobe for the operation |
| mode | input | 1 | 0 = accumulator form, 1 = prefixed register form |
| operand | input | 8 | Byte to rotate |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Captured rotated byte |
| flag_z | output | 1 | Captured zero flag |
| flag_n | output | 1 | Captured subtract flag |
| flag_h | output | 1 | Captured half-carry flag |
| flag_c | output | 1 | Captured carry flag |
| cycles | output | 5 | Captured instruction cost in clock ticks |
| valid_out | output | 1 | High for one cycle after a capture |

## Verification
The bench aims at operands whose rotated value is zero: 0x80 with carry clear, and 0x00 with carry clear. These run in both modes. A design that tied the zero flag to the result in accumulator form, or forced it low in register form, shows a wrong `flag_z` there. Operands 0x7F and 0xFF paired with both carry values separate carry-out from carry-in. A swapped or dropped bit leaves the wrong value in bit 0 or in `flag_c`. A hold scenario changes the data inputs while the strobe is low, so a wrapper that captures regardless of `valid_in` shows a changed output.

// File: rtl/rlc_pkg.sv
// Package: shared types for the rotate-through-carry unit.
// Assumes an 8-bit datapath; the mode encoding is fixed at one bit.
package rlc_pkg;

    // Instruction form selected by the mode pin.
    typedef enum logic {
        MODE_ACC = 1'b0,
        MODE_REG = 1'b1
    } rot_mode_e;

    // Condition flags produced by the unit.
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/rlc_rotate_core.sv
// Module: rlc_rotate_core
// Rotates an operand left one place through the carry.
// Assumes DATA_W >= 2; purely combinational.
module rlc_rotate_core #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    localparam int MSB = DATA_W - 1;

    // Purpose: shift the operand up and feed the old carry in at bit 0.
    always_comb begin
        res_o  = {op_i[MSB-1:0], cin_i};
        cout_o = op_i[MSB];
    end

endmodule

// File: rtl/rlc_flag_gen.sv
// Module: rlc_flag_gen
// Builds the four flags from the rotate output and the instruction form.
// Assumes the rotate core already supplies the carry out.
module rlc_flag_gen
    import rlc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              cout_i,
    input  rot_mode_e         mode_i,
    output flags_t            flags_o
);

    logic res_is_zero;

    // Purpose: detect an all-zero rotate result.
    always_comb begin
        res_is_zero = (res_i == '0);
    end

    // Purpose: set zero per mode; subtract and half-carry are always low.
    always_comb begin
        flags_o.n = 1'b0;
        flags_o.h = 1'b0;
        flags_o.c = cout_i;
        if (mode_i == MODE_REG) begin
            flags_o.z = res_is_zero;
        end else begin
            flags_o.z = 1'b0;
        end
    end

endmodule

// File: rtl/rlc_cost_sel.sv
// Module: rlc_cost_sel
// Returns the tick cost of the selected instruction form.
// Assumes both costs fit in CYC_W bits.
module rlc_cost_sel
    import rlc_pkg::*;
#(
    parameter int CYC_W    = 5,
    parameter int ACC_COST = 4,
    parameter int REG_COST = 8
) (
    input  rot_mode_e        mode_i,
    output logic [CYC_W-1:0] cycles_o
);

    localparam logic [CYC_W-1:0] ACC_C = CYC_W'(ACC_COST);
    localparam logic [CYC_W-1:0] REG_C = CYC_W'(REG_COST);

    // Purpose: pick the cost for the current form.
    always_comb begin
        cycles_o = (mode_i == MODE_REG) ? REG_C : ACC_C;
    end

endmodule

// File: rtl/rlc_unit.sv
// Module: rlc_unit
// Registered wrapper around the rotate, flag and cost logic.
// It captures the outputs on a valid strobe and holds them otherwise.
// Assumes a single clock domain and a synchronous active-low reset.
module rlc_unit
    import rlc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CYC_W    = 5,
    parameter int ACC_COST = 4,
    parameter int REG_COST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              mode,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c,
    output logic [CYC_W-1:0]  cycles,
    output logic              valid_out
);

    rot_mode_e         mode_e;
    logic [DATA_W-1:0] rot_res;
    logic              rot_cout;
    flags_t            rot_flags;
    logic [CYC_W-1:0]  rot_cycles;

    // Purpose: map the plain mode pin onto the enum type.
    always_comb begin
        mode_e = rot_mode_e'(mode);
    end

    rlc_rotate_core #(.DATA_W(DATA_W)) u_core (
        .op_i   (operand),
        .cin_i  (carry_in),
        .res_o  (rot_res),
        .cout_o (rot_cout)
    );

    rlc_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res_i   (rot_res),
        .cout_i  (rot_cout),
        .mode_i  (mode_e),
        .flags_o (rot_flags)
    );

    rlc_cost_sel #(
        .CYC_W    (CYC_W),
        .ACC_COST (ACC_COST),
        .REG_COST (REG_COST)
    ) u_cost (
        .mode_i   (mode_e),
        .cycles_o (rot_cycles)
    );

    // Purpose: capture the datapath on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
            flag_h <= 1'b0;
            flag_c <= 1'b0;
            cycles <= '0;
        end else if (valid_in) begin
            result <= rot_res;
            flag_z <= rot_flags.z;
            flag_n <= rot_flags.n;
            flag_h <= rot_flags.h;
            flag_c <= rot_flags.c;
            cycles <= rot_cycles;
        end
    end

    // Purpose: delay the strobe by one cycle to mark fresh outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
        end
    end

    // R2: captured result is the operand moved up with the old carry at bit 0.
    a_r2_result_rotated: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> result == {$past(operand[DATA_W-2:0]), $past(carry_in)});

    // R3: carry out is the former top bit.
    a_r3_carry_from_msb: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> flag_c == $past(operand[DATA_W-1]));

    // R4: subtract and half-carry never set.
    a_r4_n_h_clear: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (!flag_n && !flag_h));

    // R5: accumulator form never reports zero.
    a_r5_acc_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !$past(mode)) |-> !flag_z);

    // R6: register form reports zero exactly on an all-zero result.
    a_r6_reg_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && $past(mode)) |-> flag_z == (result == '0));

    // R7: cost follows the form.
    a_r7_cost: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> cycles == ($past(mode) ? CYC_W'(REG_COST) : CYC_W'(ACC_COST)));

    // R8: outputs hold when no strobe is given.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !valid_in) |=> ($stable(result) && $stable(flag_z) && $stable(flag_c)
                                  && $stable(cycles)));

    // R9: valid_out follows a strobe by exactly one edge.
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && valid_in) |=> valid_out);

endmodule

// File: tb/sim_rlc_unit.sv
// Directed bench for rlc_unit: one task per scenario, each checking itself.
module sim_rlc_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid_in;
    logic       mode;
    logic [7:0] operand;
    logic       carry_in;
    logic [7:0] result;
    logic       flag_z, flag_n, flag_h, flag_c;
    logic [4:0] cycles;
    logic       valid_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rlc_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .mode      (mode),
        .operand   (operand),
        .carry_in  (carry_in),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_h    (flag_h),
        .flag_c    (flag_c),
        .cycles    (cycles),
        .valid_out (valid_out)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    // Drive one strobed operation, then sample at the following falling edge.
    task automatic run_op(input logic m, input logic [7:0] op, input logic ci);
        logic [7:0] exp_res;
        logic       exp_z;
        exp_res = (op << 1) | {7'd0, ci};
        exp_z   = m && (exp_res == 8'h00);
        @(negedge clk);
        valid_in = 1'b1;
        mode     = m;
        operand  = op;
        carry_in = ci;
        @(negedge clk);
        valid_in = 1'b0;
        chk("R2 result", result, exp_res);
        chk("R3 carry", flag_c, op[7]);
        chk("R4 n flag", flag_n, 0);
        chk("R4 h flag", flag_h, 0);
        if (m) chk("R6 zero reg form", flag_z, exp_z);
        else   chk("R5 zero acc form", flag_z, 0);
        chk("R7 cycles", cycles, m ? 8 : 4);
        chk("R9 valid_out high", valid_out, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; valid_in = 1'b1; mode = 1'b1; operand = 8'hFF; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 result", result, 0);
        chk("R1 flag_z", flag_z, 0);
        chk("R1 flag_c", flag_c, 0);
        chk("R1 n/h", {flag_n, flag_h}, 0);
        chk("R1 cycles", cycles, 0);
        chk("R1 valid_out", valid_out, 0);
        valid_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_acc_patterns();
        run_op(1'b0, 8'h55, 1'b0);
        run_op(1'b0, 8'hAA, 1'b1);
        run_op(1'b0, 8'h7F, 1'b1);
        run_op(1'b0, 8'hFF, 1'b0);
        run_op(1'b0, 8'h00, 1'b0);   // R5: zero result, flag stays low
    endtask

    task automatic t_reg_patterns();
        run_op(1'b1, 8'h01, 1'b0);
        run_op(1'b1, 8'hC3, 1'b1);
        run_op(1'b1, 8'h7F, 1'b0);
        run_op(1'b1, 8'hFF, 1'b1);
        run_op(1'b1, 8'h00, 1'b0);   // R6: zero result sets zero
        run_op(1'b1, 8'h00, 1'b1);   // R6: result 0x01, zero clear
    endtask

    task automatic t_r10_boundary();
        run_op(1'b0, 8'h80, 1'b0);
        chk("R10 acc result", result, 8'h00);
        chk("R10 acc carry", flag_c, 1);
        chk("R10 acc zero", flag_z, 0);
        run_op(1'b1, 8'h80, 1'b0);
        chk("R10 reg result", result, 8'h00);
        chk("R10 reg carry", flag_c, 1);
        chk("R10 reg zero", flag_z, 1);
    endtask

    task automatic t_hold();
        run_op(1'b1, 8'h80, 1'b0);   // leaves result 0x00, z=1, c=1, cycles 8
        @(negedge clk);
        valid_in = 1'b0; mode = 1'b0; operand = 8'h3C; carry_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 result held", result, 8'h00);
        chk("R8 zero held", flag_z, 1);
        chk("R8 carry held", flag_c, 1);
        chk("R8 cycles held", cycles, 8);
        chk("R9 valid_out low", valid_out, 0);
    endtask

    initial begin
        t_reset();
        t_acc_patterns();
        t_reg_patterns();
        t_r10_boundary();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule